// File: doc/BRIEF.md
# Flash Erase Block Selector

This block holds the software choice of which flash erase block the next erase cycle targets. Two byte-wide selection registers sit on a small register bus. The low register picks one of the small boot-area blocks. The high register picks one of the larger main-area blocks. Hardware makes sure that at most one bit is set across both registers together. Any write that would leave two or more bits set clears both registers.

Both registers follow a software write-enable input that comes from a separate flash control register. While that input is low, both registers are held at zero and bus writes have no effect.

From the stored selection the block derives a one-hot selection vector, an encoded block index with a valid flag, and the base address and byte size of the chosen block. An erase sequencer uses the base and size to address the array.

Top module: `erase_blk_sel`

## Requirements
- R1: After the active-low reset, both registers read 0x00, `sel_o` is 0, `valid_o` is 0, and `idx_o`, `base_o` and `size_o` are 0.
- R2: With `swe_i` high, a write to address 0 that leaves at most one bit set across both registers stores `wdata_i` in the low register. `rdata_o` returns the low register whenever `addr_i` is 0, and reading has no side effect.
- R3: With `swe_i` high, a write to address 1 that leaves at most one bit set across both registers stores `wdata_i` in the high register. `rdata_o` returns the high register whenever `addr_i` is 1.
- R4: While `swe_i` is 0, both registers are cleared and held at 0x00 on every clock, and writes do not change them. Raising `swe_i` again does not bring back any earlier value.
- R5: A single write of a value with two or more bits set clears both registers to 0x00.
- R6: The hardware forms the merged value from the newly written register and the other register, which keeps its old contents. If that merged value has more than one bit set, both registers are cleared. A write that replaces the only set bit within the same register is therefore accepted.
- R7: `sel_o` is {high register, low register}. Bit n of the low register selects block n, and bit n of the high register selects block 8+n.
- R8: `valid_o` is 1 only when exactly one bit of `sel_o` is set. In that case `idx_o` is the position of that bit. Otherwise `idx_o` is 0.
- R9: `size_o` is 4096 for blocks 0 to 7. For blocks 8 to 15 it is the entry for that block in the size table, which is 32768 by default. `size_o` is 0 when `valid_o` is 0.
- R10: `base_o` is the sum of the sizes of all lower-numbered blocks, counted from address 0. With the default sizes, block b<8 starts at b*4096 and block 8+k starts at 32768+k*32768. `base_o` is 0 when `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| swe_i | input | 1 | Software write enable from the flash control register |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register address: 0 for the low register, 1 for the high register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Contents of the addressed register |
| sel_o | output | 16 | One-hot block selection |
| idx_o | output | 4 | Encoded block index |
| valid_o | output | 1 | Exactly one block is selected |
| base_o | output | 32 | Byte base address of the selected block |
| size_o | output | 32 | Byte size of the selected block |

## Verification
An accepted write, a conflict clear and a clear caused by `swe_i` all take effect at the first rising edge at which the condition is present. The selection, index, valid, base and size outputs are combinational from the registers, so they are due in that same cycle. `rdata_o` follows `addr_i` with no delay. The bench changes inputs on falling edges and samples one time unit after the next falling edge, which leaves exactly one rising edge between a stimulus and its check. It sweeps every block, then every write value to each register under both an empty and an occupied opposite register, and computes the expected register contents and geometry arithmetically.

// File: rtl/erase_sel_pkg.sv
package erase_sel_pkg;
  typedef enum logic {
    REG_LO = 1'b0,
    REG_HI = 1'b1
  } reg_sel_e;

  localparam int unsigned DEF_REG_W   = 8;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_LO_SIZE = 4096;
  localparam int unsigned DEF_HI_SIZE = 32768;
endpackage

// File: rtl/erase_sel_regs.sv
module erase_sel_regs
  import erase_sel_pkg::*;
#(
  parameter int unsigned REG_W = DEF_REG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swe_i,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] lo_o,
  output logic [REG_W-1:0] hi_o
);
  logic [REG_W-1:0]   lo_q, hi_q, lo_nx, hi_nx;
  logic [2*REG_W-1:0] merged;
  logic               multi;

  // candidate contents: written register replaced, other kept
  always_comb begin
    lo_nx = lo_q;
    hi_nx = hi_q;
    if (reg_sel_e'(addr_i) == REG_HI) hi_nx = wdata_i;
    else                              lo_nx = wdata_i;
    merged = {hi_nx, lo_nx};
    multi  = ($countones(merged) > 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (!swe_i) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we_i) begin
      if (multi) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        lo_q <= lo_nx;
        hi_q <= hi_nx;
      end
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/erase_sel_encode.sv
module erase_sel_encode #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     sel_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o
);
  logic [IDX_W-1:0] idx_or;

  always_comb begin
    idx_or = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_i[i]) idx_or = idx_or | IDX_W'(i);
    end
  end

  assign valid_o = ($countones(sel_i) == 1);
  assign idx_o   = valid_o ? idx_or : '0;
endmodule

// File: rtl/erase_sel_geom.sv
module erase_sel_geom #(
  parameter int unsigned                  REG_W       = 8,
  parameter int unsigned                  ADDR_W      = 32,
  parameter int unsigned                  LO_SIZE     = 4096,
  parameter logic [REG_W*ADDR_W-1:0]      HI_SIZE_TBL = {REG_W{ADDR_W'(32768)}},
  parameter int unsigned                  IDX_W       = $clog2(2*REG_W)
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              valid_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o
);
  localparam int unsigned NBLK = 2 * REG_W;

  logic [ADDR_W-1:0] acc, sz, base_c, size_c;

  // walk blocks in order, accumulating sizes into the base
  always_comb begin
    acc    = '0;
    base_c = '0;
    size_c = '0;
    for (int b = 0; b < NBLK; b++) begin
      if (b < REG_W) sz = ADDR_W'(LO_SIZE);
      else           sz = HI_SIZE_TBL[(b-REG_W)*ADDR_W +: ADDR_W];
      if (idx_i == IDX_W'(b)) begin
        base_c = acc;
        size_c = sz;
      end
      acc = acc + sz;
    end
  end

  assign base_o = valid_i ? base_c : '0;
  assign size_o = valid_i ? size_c : '0;
endmodule

// File: rtl/erase_blk_sel.sv
module erase_blk_sel
  import erase_sel_pkg::*;
#(
  parameter int unsigned             REG_W       = DEF_REG_W,
  parameter int unsigned             ADDR_W      = DEF_ADDR_W,
  parameter int unsigned             LO_SIZE     = DEF_LO_SIZE,
  parameter logic [REG_W*ADDR_W-1:0] HI_SIZE_TBL = {REG_W{ADDR_W'(DEF_HI_SIZE)}},
  localparam int unsigned            NBLK        = 2 * REG_W,
  localparam int unsigned            IDX_W       = $clog2(NBLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              swe_i,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [NBLK-1:0]   sel_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] size_o
);
  logic [REG_W-1:0] lo, hi;

  erase_sel_regs #(.REG_W(REG_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .swe_i   (swe_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .lo_o    (lo),
    .hi_o    (hi)
  );

  assign sel_o   = {hi, lo};
  assign rdata_o = (reg_sel_e'(addr_i) == REG_HI) ? hi : lo;

  erase_sel_encode #(.N(NBLK), .IDX_W(IDX_W)) u_enc (
    .sel_i   (sel_o),
    .idx_o   (idx_o),
    .valid_o (valid_o)
  );

  erase_sel_geom #(
    .REG_W       (REG_W),
    .ADDR_W      (ADDR_W),
    .LO_SIZE     (LO_SIZE),
    .HI_SIZE_TBL (HI_SIZE_TBL),
    .IDX_W       (IDX_W)
  ) u_geom (
    .idx_i   (idx_o),
    .valid_i (valid_o),
    .base_o  (base_o),
    .size_o  (size_o)
  );
endmodule

// File: rtl/erase_blk_sel_chk.sv
module erase_blk_sel_chk #(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LO_SIZE = 4096,
  parameter int unsigned NBLK    = 2 * REG_W,
  parameter int unsigned IDX_W   = $clog2(NBLK)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              swe_i,
  input logic              we_i,
  input logic              addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [NBLK-1:0]   sel_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic              valid_o,
  input logic [ADDR_W-1:0] base_o,
  input logic [ADDR_W-1:0] size_o
);
  // R4
  swe_hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swe_i |=> (sel_o == '0));

  // R5
  at_most_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));

  // R2
  lo_zero_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swe_i && we_i && !addr_i && wdata_i == '0) |=> (sel_o[REG_W-1:0] == '0));

  // R3
  hi_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> (rdata_o == sel_o[NBLK-1:REG_W]));

  // R8
  idx_points_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sel_o[idx_o]);

  // R9
  lo_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && idx_o < IDX_W'(REG_W)) |-> (size_o == ADDR_W'(LO_SIZE)));

  // R10
  idle_geom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (base_o == '0 && size_o == '0 && idx_o == '0));
endmodule

bind erase_blk_sel erase_blk_sel_chk #(
  .REG_W   (REG_W),
  .ADDR_W  (ADDR_W),
  .LO_SIZE (LO_SIZE)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .swe_i   (swe_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .sel_o   (sel_o),
  .idx_o   (idx_o),
  .valid_o (valid_o),
  .base_o  (base_o),
  .size_o  (size_o)
);

// File: tb/sim_erase_blk_sel.sv
`timescale 1ns/1ps
module sim_erase_blk_sel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        swe_i = 1'b0;
  logic        we_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] sel_o;
  logic [3:0]  idx_o;
  logic        valid_o;
  logic [31:0] base_o, size_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lo = '0, m_hi = '0;

  always #10 clk_i = ~clk_i;

  erase_blk_sel u0 (
    .clk_i, .rst_ni, .swe_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .sel_o, .idx_o, .valid_o, .base_o, .size_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int cnt8(logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return c;
  endfunction

  // expected model of one accepted write, from R2/R3/R5/R6
  task automatic model_wr(logic a, logic [7:0] d);
    logic [7:0] nl = a ? m_lo : d;
    logic [7:0] nh = a ? d : m_hi;
    if (!swe_i) begin
      m_lo = '0; m_hi = '0;
    end else if (cnt8(nl) + cnt8(nh) > 1) begin
      m_lo = '0; m_hi = '0;
    end else begin
      m_lo = nl; m_hi = nh;
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    model_wr(a, d);
    #1;
  endtask

  task automatic check_all(string req);
    logic [15:0] s = {m_hi, m_lo};
    int n = cnt8(m_lo) + cnt8(m_hi);
    int b = 0;
    logic [31:0] eb = '0, es = '0;
    for (int i = 0; i < 16; i++) if (s[i]) b = i;
    if (n == 1) begin
      es = (b < 8) ? 32'd4096 : 32'd32768;
      eb = (b < 8) ? 32'(b) * 32'd4096 : 32'd32768 + 32'(b - 8) * 32'd32768;
    end
    check({req, " sel R7"}, 32'(sel_o), 32'(s));
    check({req, " valid R8"}, 32'(valid_o), 32'(n == 1));
    check({req, " idx R8"}, 32'(idx_o), (n == 1) ? 32'(b) : 32'd0);
    check({req, " size R9"}, size_o, es);
    check({req, " base R10"}, base_o, eb);
    addr_i = 1'b0; #1;
    check({req, " rd lo R2"}, 32'(rdata_o), 32'(m_lo));
    addr_i = 1'b1; #1;
    check({req, " rd hi R3"}, 32'(rdata_o), 32'(m_hi));
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    check_all("R1 reset");
    @(negedge clk_i); rst_ni = 1'b1; swe_i = 1'b1;
    @(negedge clk_i); #1;
    check_all("R1 after reset");

    // every block alone, then cleared by a zero write (R2 R3 R7 R9 R10)
    for (int b = 0; b < 16; b++) begin
      wr(b >= 8, 8'(1 << (b % 8)));
      check_all("R9 R10 sweep");
      wr(b >= 8, 8'h00);
      check_all("R2 clear");
    end

    // every value into each register, opposite empty then occupied (R5 R6)
    for (int a = 0; a < 2; a++) begin
      for (int occ = 0; occ < 2; occ++) begin
        for (int d = 0; d < 256; d++) begin
          wr(a == 0, occ ? 8'h10 : 8'h00);
          wr(a == 0, 8'h00);
          if (occ != 0) wr(a == 0, 8'h10);
          wr(a[0], 8'(d));
          check_all(occ ? "R6 cross" : "R5 multi");
        end
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
      end
    end

    // same-register replacement accepted (R6)
    wr(1'b0, 8'h08); wr(1'b0, 8'h20);
    check_all("R6 replace");
    check(" R6 replace lo", 32'(sel_o), 32'h0020);
    // explicit conflict
    wr(1'b1, 8'h01);
    check("R6 conflict", 32'(sel_o), 32'h0000);

    // swe low: forced clear and writes ignored (R4)
    wr(1'b1, 8'h40);
    check("R4 pre", 32'(sel_o), 32'h4000);
    @(negedge clk_i); swe_i = 1'b0; m_lo = '0; m_hi = '0;
    @(negedge clk_i); #1;
    check("R4 forced clear", 32'(sel_o), 32'h0000);
    wr(1'b0, 8'h02);
    check_all("R4 write ignored");
    @(negedge clk_i); swe_i = 1'b1;
    @(negedge clk_i); #1;
    check_all("R4 reenabled");
    check("R4 no restore", 32'(sel_o), 32'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule